// File: doc/BRIEF.md
# Line-Code Rail Interface

This block joins a framer-side bit interface to an internal bipolar line representation, in which each bit clock carries one positive-pulse bit and one negative-pulse bit. Two static control inputs choose how the framer side is read. In single-rail operation the framer supplies unipolar NRZ transmit data. The block turns it into alternating-polarity marks (AMI), or into HDB3 when the coding input is high. Received pulses are folded back into one unipolar data stream, and line-code errors are reported on a violation output. In dual-rail operation the framer drives and receives the positive and negative rails directly as NRZ signals. A second polarity setting then makes all four rail signals active-low and inverts the receive clock.

Four framer-side pins take a different meaning in each mode. The coding-enable input doubles as the transmit n-rail input. The violation output doubles as the receive n-rail output. The unipolar receive output doubles as the receive p-rail output, and the unipolar transmit input doubles as the transmit p-rail input. The configuration decoder has four named states: CFG_SR_LM1, CFG_SR_ILLEGAL, CFG_DR_LM1 and CFG_DR_LM2. The transmit polarity machine has two states, TXP_LAST_NEG and TXP_LAST_POS. A mark or a B symbol toggles it; a V symbol leaves it unchanged. The receive machine moves from RXS_IDLE to RXS_LAST_POS or RXS_LAST_NEG on each single-rail mark. A pulse on both rails at once does not move it. Leaving single-rail operation returns both machines to their reset state.

Top module: `line_rail_if`

## Requirements
- R1: While rst_n is low, line_pos_o, line_neg_o, viol_rn_o and rxd_rp_o are 0. Reset leaves the transmit polarity machine in TXP_LAST_NEG (the next mark is positive), the receive machine in RXS_IDLE and the HDB3 mark parity even.
- R2: In single-rail operation with hdb3_tn_i low, a 1 on txd_tp_i produces a pulse on exactly one of line_pos_o/line_neg_o one clock later. Successive marks alternate in polarity, starting positive after reset, and a 0 produces no pulse.
- R3: In single-rail operation with hdb3_tn_i low, a pulse on either received rail sets rxd_rp_o to 1 one clock later. No pulse gives 0.
- R4: In single-rail operation, viol_rn_o is high for one bit, together with rxd_rp_o = 1, when a received mark has the same polarity as the previous mark. It also goes high when both received rails are high at once, and that event leaves the expected polarity unchanged. The first mark after reset or after leaving dual-rail operation is never a violation.
- R5: With dual_mode_i = 1 and alt_pol_i = 0, one clock after each input: line_pos_o = txd_tp_i, line_neg_o = hdb3_tn_i, rxd_rp_o = line_pos_i, viol_rn_o = line_neg_i. No coding and no violation reporting take place.
- R6: With dual_mode_i = 1 and alt_pol_i = 1, the same four paths carry inverted data, and rclk_o is the inverse of rclk_i. In every other configuration rclk_o follows rclk_i.
- R7: dual_mode_i = 0 with alt_pol_i = 1 behaves exactly as single-rail with normal polarity and drives cfg_err_o high. cfg_err_o is low for every other configuration.
- R8: With HDB3 on, four transmit zeros in a row become 000V when an odd number of marks have been sent since the last V, and B00V when that number is even. V has the polarity of the previous pulse; B alternates like a normal mark.
- R9: With HDB3 on, the transmit and receive paths each take five clocks from input to output: four for lookahead plus the output register.
- R10: With HDB3 on, a received mark that repeats the previous polarity and follows at least two decoded zeros ends a substitution. It is decoded as zero, the mark three bits earlier is also cleared to zero, and no violation is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode_i | input | 1 | 0 = single-rail, 1 = dual-rail |
| alt_pol_i | input | 1 | 1 selects active-low rails and inverted receive clock (dual-rail only) |
| hdb3_tn_i | input | 1 | HDB3 enable (single-rail) / transmit n-rail (dual-rail) |
| txd_tp_i | input | 1 | Unipolar transmit data (single-rail) / transmit p-rail (dual-rail) |
| viol_rn_o | output | 1 | Violation flag (single-rail) / receive n-rail (dual-rail) |
| rxd_rp_o | output | 1 | Unipolar receive data (single-rail) / receive p-rail (dual-rail) |
| line_pos_o | output | 1 | Transmit positive-pulse bit to line side |
| line_neg_o | output | 1 | Transmit negative-pulse bit to line side |
| line_pos_i | input | 1 | Received positive-pulse bit from line side |
| line_neg_i | input | 1 | Received negative-pulse bit from line side |
| rclk_i | input | 1 | Recovered receive clock |
| rclk_o | output | 1 | Receive clock to framer, inverted in the alternate polarity mode |
| cfg_err_o | output | 1 | High for the illegal single-rail plus alternate-polarity setting |

## Verification
The bench builds the block with the default lookahead depth of four, the only depth at which the substitution patterns are defined. With that depth, one stream reaches both the 000V and the B00V forms, including a parity count that restarts at each V and B00V runs that follow each other directly. The matching receive stream decodes both forms back to zeros and puts a real repeated-polarity mark and a both-rails pulse next to them, so the five-clock alignment of data and violation flag is checked bit by bit.

// File: rtl/line_rail_pkg.sv
package line_rail_pkg;

    // Length of a zero run that HDB3 replaces, and the lookahead depth.
    localparam int RUN_LEN = 4;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BIP  = 2'd2,
        SYM_VIO  = 2'd3
    } sym_t;

    typedef enum logic {
        TXP_LAST_NEG = 1'b0,
        TXP_LAST_POS = 1'b1
    } tx_pol_t;

    typedef enum logic [1:0] {
        RXS_IDLE     = 2'd0,
        RXS_LAST_POS = 2'd1,
        RXS_LAST_NEG = 2'd2
    } rx_st_t;

    typedef enum logic [1:0] {
        CFG_SR_LM1     = 2'd0,
        CFG_SR_ILLEGAL = 2'd1,
        CFG_DR_LM1     = 2'd2,
        CFG_DR_LM2     = 2'd3
    } cfg_t;

endpackage

// File: rtl/rail_cfg_decode.sv
module rail_cfg_decode
    import line_rail_pkg::*;
(
    input  logic dual_mode_i,
    input  logic alt_pol_i,
    output cfg_t cfg_o,
    output logic single_o,
    output logic invert_o,
    output logic err_o
);

    always_comb begin
        unique case ({dual_mode_i, alt_pol_i})
            2'b00:   cfg_o = CFG_SR_LM1;
            2'b01:   cfg_o = CFG_SR_ILLEGAL;
            2'b10:   cfg_o = CFG_DR_LM1;
            2'b11:   cfg_o = CFG_DR_LM2;
            default: cfg_o = CFG_SR_LM1;
        endcase
    end

    always_comb begin
        single_o = 1'b0;
        invert_o = 1'b0;
        err_o    = 1'b0;
        unique case (cfg_o)
            CFG_SR_LM1:     single_o = 1'b1;
            CFG_SR_ILLEGAL: begin
                single_o = 1'b1;
                err_o    = 1'b1;
            end
            CFG_DR_LM1:     ;
            CFG_DR_LM2:     invert_o = 1'b1;
            default:        single_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rail_hdb3_tx.sv
module rail_hdb3_tx
    import line_rail_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hdb3_en,
    input  logic data_i,
    output logic pos_o,
    output logic neg_o
);

    localparam int LAST = DEPTH - 1;

    sym_t    pipe_q [DEPTH];
    sym_t    new_sym;
    sym_t    out_sym;
    tx_pol_t pol_q;
    tx_pol_t pol_d;
    logic    par_q;
    logic    par_d;
    logic    run_zero;
    logic    is_mark;
    logic    pos_d;
    logic    neg_d;

    // Symbol selection and zero-run lookahead.
    always_comb begin
        new_sym  = data_i ? SYM_ONE : SYM_ZERO;
        run_zero = !data_i;
        for (int i = 0; i < LAST; i++) begin
            if (pipe_q[i] != SYM_ZERO) run_zero = 1'b0;
        end
        out_sym = hdb3_en ? pipe_q[LAST] : new_sym;
        is_mark = (out_sym == SYM_ONE) || (out_sym == SYM_BIP);
        par_d   = (out_sym == SYM_VIO) ? 1'b0 : (par_q ^ is_mark);
    end

    // Polarity machine next state and pulse decode.
    always_comb begin
        pol_d = pol_q;
        pos_d = 1'b0;
        neg_d = 1'b0;
        unique case (out_sym)
            SYM_ZERO: ;
            SYM_ONE, SYM_BIP: begin
                if (pol_q == TXP_LAST_NEG) begin
                    pos_d = 1'b1;
                    pol_d = TXP_LAST_POS;
                end else begin
                    neg_d = 1'b1;
                    pol_d = TXP_LAST_NEG;
                end
            end
            SYM_VIO: begin
                pos_d = (pol_q == TXP_LAST_POS);
                neg_d = (pol_q == TXP_LAST_NEG);
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= TXP_LAST_NEG;
            par_q <= 1'b0;
        end else if (!en) begin
            pol_q <= TXP_LAST_NEG;
            par_q <= 1'b0;
        end else begin
            pol_q <= pol_d;
            par_q <= par_d;
        end
    end

    // Lookahead pipeline with in-place substitution.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= SYM_ZERO;
        end else if (!en || !hdb3_en) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= SYM_ZERO;
        end else if (run_zero) begin
            pipe_q[0] <= SYM_VIO;
            for (int i = 1; i < LAST; i++) pipe_q[i] <= SYM_ZERO;
            pipe_q[LAST] <= par_d ? SYM_ZERO : SYM_BIP;
        end else begin
            pipe_q[0] <= new_sym;
            for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_o <= 1'b0;
            neg_o <= 1'b0;
        end else if (!en) begin
            pos_o <= 1'b0;
            neg_o <= 1'b0;
        end else begin
            pos_o <= pos_d;
            neg_o <= neg_d;
        end
    end

endmodule

// File: rtl/rail_hdb3_rx.sv
module rail_hdb3_rx
    import line_rail_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hdb3_en,
    input  logic pos_i,
    input  logic neg_i,
    output logic data_o,
    output logic viol_o
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] dat_q;
    logic [DEPTH-1:0] vio_q;
    rx_st_t           st_q;
    rx_st_t           st_d;
    logic             mark;
    logic             both;
    logic             same;
    logic             sub;
    logic             new_d;
    logic             new_v;
    logic             data_d;
    logic             viol_d;

    always_comb begin
        mark   = pos_i ^ neg_i;
        both   = pos_i & neg_i;
        same   = mark && (((st_q == RXS_LAST_POS) && pos_i) ||
                          ((st_q == RXS_LAST_NEG) && neg_i));
        sub    = hdb3_en && same && !dat_q[0] && !dat_q[1];
        new_d  = !sub && (mark || both);
        new_v  = !sub && (same || both);
        data_d = hdb3_en ? dat_q[LAST] : new_d;
        viol_d = hdb3_en ? vio_q[LAST] : new_v;
    end

    // Receive polarity machine next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RXS_IDLE, RXS_LAST_POS, RXS_LAST_NEG: begin
                if (mark) st_d = pos_i ? RXS_LAST_POS : RXS_LAST_NEG;
            end
            default: st_d = RXS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= RXS_IDLE;
        else if (!en) st_q <= RXS_IDLE;
        else          st_q <= st_d;
    end

    // Decode pipeline; a closing V clears the three bits behind it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            vio_q <= '0;
        end else if (!en || !hdb3_en) begin
            dat_q <= '0;
            vio_q <= '0;
        end else begin
            dat_q <= {(sub ? {(DEPTH-1){1'b0}} : dat_q[DEPTH-2:0]), new_d};
            vio_q <= {(sub ? {(DEPTH-1){1'b0}} : vio_q[DEPTH-2:0]), new_v};
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= 1'b0;
            viol_o <= 1'b0;
        end else if (!en) begin
            data_o <= 1'b0;
            viol_o <= 1'b0;
        end else begin
            data_o <= data_d;
            viol_o <= viol_d;
        end
    end

endmodule

// File: rtl/line_rail_if.sv
module line_rail_if
    import line_rail_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode_i,
    input  logic alt_pol_i,
    input  logic hdb3_tn_i,
    input  logic txd_tp_i,
    output logic viol_rn_o,
    output logic rxd_rp_o,
    output logic line_pos_o,
    output logic line_neg_o,
    input  logic line_pos_i,
    input  logic line_neg_i,
    input  logic rclk_i,
    output logic rclk_o,
    output logic cfg_err_o
);

    cfg_t cfg;
    logic single;
    logic invert;
    logic hdb3_en;
    logic enc_pos;
    logic enc_neg;
    logic dec_data;
    logic dec_viol;
    logic dual_q;
    logic dr_tp_q;
    logic dr_tn_q;
    logic dr_rp_q;
    logic dr_rn_q;

    rail_cfg_decode u_cfg (
        .dual_mode_i (dual_mode_i),
        .alt_pol_i   (alt_pol_i),
        .cfg_o       (cfg),
        .single_o    (single),
        .invert_o    (invert),
        .err_o       (cfg_err_o)
    );

    assign hdb3_en = single & hdb3_tn_i;

    rail_hdb3_tx #(.DEPTH(DEPTH)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (single),
        .hdb3_en (hdb3_en),
        .data_i  (txd_tp_i),
        .pos_o   (enc_pos),
        .neg_o   (enc_neg)
    );

    rail_hdb3_rx #(.DEPTH(DEPTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (single),
        .hdb3_en (hdb3_en),
        .pos_i   (line_pos_i),
        .neg_i   (line_neg_i),
        .data_o  (dec_data),
        .viol_o  (dec_viol)
    );

    // Dual-rail pass-through registers and registered mode select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dual_q  <= 1'b0;
            dr_tp_q <= 1'b0;
            dr_tn_q <= 1'b0;
            dr_rp_q <= 1'b0;
            dr_rn_q <= 1'b0;
        end else begin
            dual_q  <= (cfg == CFG_DR_LM1) || (cfg == CFG_DR_LM2);
            dr_tp_q <= txd_tp_i   ^ invert;
            dr_tn_q <= hdb3_tn_i  ^ invert;
            dr_rp_q <= line_pos_i ^ invert;
            dr_rn_q <= line_neg_i ^ invert;
        end
    end

    always_comb begin
        line_pos_o = dual_q ? dr_tp_q : enc_pos;
        line_neg_o = dual_q ? dr_tn_q : enc_neg;
        rxd_rp_o   = dual_q ? dr_rp_q : dec_data;
        viol_rn_o  = dual_q ? dr_rn_q : dec_viol;
        rclk_o     = rclk_i ^ invert;
    end

endmodule

// File: rtl/line_rail_if_chk.sv
module line_rail_if_chk (
    input logic clk,
    input logic rst_n,
    input logic dual_mode_i,
    input logic alt_pol_i,
    input logic hdb3_tn_i,
    input logic txd_tp_i,
    input logic viol_rn_o,
    input logic rxd_rp_o,
    input logic line_pos_o,
    input logic line_neg_o,
    input logic line_pos_i,
    input logic line_neg_i,
    input logic cfg_err_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!line_pos_o && !line_neg_o && !viol_rn_o && !rxd_rp_o);
        end
    end

    assert_sr_one_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(dual_mode_i)) |-> !(line_pos_o && line_neg_o));

    assert_viol_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(dual_mode_i) && viol_rn_o) |-> rxd_rp_o);

    assert_dr_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(dual_mode_i) && !$past(alt_pol_i)) |->
        ((line_pos_o == $past(txd_tp_i)) && (line_neg_o == $past(hdb3_tn_i)) &&
         (rxd_rp_o == $past(line_pos_i)) && (viol_rn_o == $past(line_neg_i))));

    assert_dr_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(dual_mode_i) && $past(alt_pol_i)) |->
        ((line_pos_o != $past(txd_tp_i)) && (line_neg_o != $past(hdb3_tn_i)) &&
         (rxd_rp_o != $past(line_pos_i)) && (viol_rn_o != $past(line_neg_i))));

    assert_err_only_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !dual_mode_i);

endmodule

bind line_rail_if line_rail_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dual_mode_i (dual_mode_i),
    .alt_pol_i   (alt_pol_i),
    .hdb3_tn_i   (hdb3_tn_i),
    .txd_tp_i    (txd_tp_i),
    .viol_rn_o   (viol_rn_o),
    .rxd_rp_o    (rxd_rp_o),
    .line_pos_o  (line_pos_o),
    .line_neg_o  (line_neg_o),
    .line_pos_i  (line_pos_i),
    .line_neg_i  (line_neg_i),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/line_rail_if_tb.sv
`timescale 1ns/100ps
module line_rail_if_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dual_mode_i = 1'b0;
    logic alt_pol_i = 1'b0;
    logic hdb3_tn_i = 1'b0;
    logic txd_tp_i = 1'b0;
    logic line_pos_i = 1'b0;
    logic line_neg_i = 1'b0;
    logic rclk_i = 1'b0;
    logic viol_rn_o, rxd_rp_o, line_pos_o, line_neg_o, rclk_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_rail_if u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dual_mode_i (dual_mode_i),
        .alt_pol_i   (alt_pol_i),
        .hdb3_tn_i   (hdb3_tn_i),
        .txd_tp_i    (txd_tp_i),
        .viol_rn_o   (viol_rn_o),
        .rxd_rp_o    (rxd_rp_o),
        .line_pos_o  (line_pos_o),
        .line_neg_o  (line_neg_o),
        .line_pos_i  (line_pos_i),
        .line_neg_i  (line_neg_i),
        .rclk_i      (rclk_i),
        .rclk_o      (rclk_o),
        .cfg_err_o   (cfg_err_o)
    );

    // Row: {dual, pol, hdb3_tn, txd_tp, lpos_in, lneg_in,
    //       exp line_pos_o, exp line_neg_o, exp viol_rn_o, exp rxd_rp_o, exp cfg_err_o}
    localparam logic [10:0] VEC [14] = '{
        11'b0_0_0_1_1_0_1_0_0_1_0, // R2 first mark positive, R3 receive mark
        11'b0_0_0_0_0_0_0_0_0_0_0, // R2 R3 zero
        11'b0_0_0_1_0_1_0_1_0_1_0, // R2 alternation
        11'b0_0_0_1_0_1_1_0_1_1_0, // R4 repeated negative
        11'b0_0_0_1_1_1_0_1_1_1_0, // R4 both rails
        11'b0_0_0_0_1_0_0_0_0_1_0, // R4 polarity kept after both rails
        11'b0_1_0_1_0_0_1_0_0_0_1, // R7 illegal acts single-rail
        11'b0_1_0_0_1_0_0_0_1_1_1, // R7 violation still reported
        11'b1_0_1_0_1_0_0_1_0_1_0, // R5 pass-through
        11'b1_0_0_1_0_1_1_0_1_0_0, // R5 pass-through
        11'b1_0_1_1_1_1_1_1_1_1_0, // R5 both rails pass
        11'b1_1_1_1_1_1_0_0_0_0_0, // R6 inverted
        11'b1_1_0_0_0_0_1_1_1_1_0, // R6 inverted
        11'b1_1_0_1_1_0_0_1_1_0_0  // R6 inverted
    };

    function automatic string row_req(input int r);
        if (r < 3)       return "R2_R3";
        else if (r < 6)  return "R4";
        else if (r < 8)  return "R7";
        else if (r < 11) return "R5";
        else             return "R6";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // HDB3 stream, bit index = time index.
    localparam logic [14:0] TX_BITS = 15'h0061;
    localparam logic [14:0] TX_POS  = 15'h4851;
    localparam logic [14:0] TX_NEG  = 15'h04A0;
    localparam logic [17:0] RX_POS  = 18'h24851;
    localparam logic [17:0] RX_NEG  = 18'h384A0;
    localparam logic [17:0] RX_DATA = 18'h38061;
    localparam logic [17:0] RX_VIOL = 18'h30000;

    initial begin
        // R1 reset state with busy inputs
        txd_tp_i = 1'b1; line_pos_i = 1'b1; line_neg_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", {4'd0, line_pos_o, line_neg_o, viol_rn_o, rxd_rp_o}, 8'h00);
        chk("R1 cfg", {7'd0, cfg_err_o}, 8'h00);
        txd_tp_i = 1'b0; line_pos_i = 1'b0; line_neg_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, latency one clock
        for (int r = 0; r < 14; r++) begin
            {dual_mode_i, alt_pol_i, hdb3_tn_i, txd_tp_i, line_pos_i, line_neg_i} = VEC[r][10:5];
            @(posedge clk);
            @(negedge clk);
            chk(row_req(r), {3'd0, line_pos_o, line_neg_o, viol_rn_o, rxd_rp_o, cfg_err_o},
                {3'd0, VEC[r][4:0]});
        end

        // R6 receive clock inversion
        dual_mode_i = 1'b1; alt_pol_i = 1'b1; rclk_i = 1'b1; #1;
        chk("R6 rclk", {7'd0, rclk_o}, 8'h00);
        alt_pol_i = 1'b0; #1;
        chk("R6 rclk", {7'd0, rclk_o}, 8'h01);
        rclk_i = 1'b0;

        // Fresh reset, then HDB3 stream (R8 R9 R10)
        @(negedge clk);
        rst_n = 1'b0; dual_mode_i = 1'b0; alt_pol_i = 1'b0; hdb3_tn_i = 1'b1;
        txd_tp_i = 1'b0; line_pos_i = 1'b0; line_neg_i = 1'b0;
        @(negedge clk);
        chk("R1 second reset", {4'd0, line_pos_o, line_neg_o, viol_rn_o, rxd_rp_o}, 8'h00);
        rst_n = 1'b1;
        for (int n = 0; n < 22; n++) begin
            txd_tp_i   = (n < 15) ? TX_BITS[n] : 1'b0;
            line_pos_i = (n < 18) ? RX_POS[n]  : 1'b0;
            line_neg_i = (n < 18) ? RX_NEG[n]  : 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (n < 4) begin
                // R9: nothing leaves before the fifth clock
                chk("R9 tx hold", {6'd0, line_pos_o, line_neg_o}, 8'h00);
                chk("R9 rx hold", {6'd0, viol_rn_o, rxd_rp_o}, 8'h00);
            end else begin
                if (n - 4 < 15)
                    chk("R8 tx symbol", {6'd0, line_pos_o, line_neg_o},
                        {6'd0, TX_POS[n-4], TX_NEG[n-4]});
                if (n - 4 < 18)
                    chk("R10 rx bit", {6'd0, viol_rn_o, rxd_rp_o},
                        {6'd0, RX_VIOL[n-4], RX_DATA[n-4]});
            end
        end

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule